// File: doc/BRIEF.md
# Masked Watchpoint Comparator

This unit watches a processor's memory bus and flags accesses of interest for a debugger. For every access marked by a valid strobe, it compares three groups of observed bits against programmed reference values: the address, the data, and a control word describing the access. The control word holds the fetch/data flag, the direction, the size, the privilege level, an external condition, a chain input from a neighbouring unit and a range input. Each group has a value register and a mask register of the same width. A mask bit set to 1 removes the matching bit from the comparison. The unit reports a hit when every unmasked bit in all three groups equals its reference bit.

The registers are loaded through a simple write port made of an enable, a 3-bit selector and a data word. The hit is registered, so it appears one clock after the strobe. The same registered hit also leaves the unit as a range output that a neighbouring unit can sample as its own range input. Several common uses come from the mask alone. An exact address needs a zero address mask. Setting low address mask bits matches an aligned block of addresses. An all-ones data mask makes the match ignore the data. Masking the direction bit or the size bits matches both directions or every size.

Top module: `wpt_match_unit`

## Requirements
- R1: After reset every value register reads as zero and every mask register as all ones, so the first strobed access after reset produces a hit. Both outputs are 0 while reset is asserted.
- R2: `wp_hit` is 1 in the cycle after a clock edge that sampled `acc_valid` high with all groups matching. After an edge with `acc_valid` low, `wp_hit` is 0.
- R3: With an all-zero address mask, only an access whose address equals the address value register hits.
- R4: Setting the low N address mask bits makes any address inside the aligned 2^N block that contains the address value hit. Addresses outside that block miss.
- R5: With an all-ones data mask the data bus has no effect on the result. With a zero data mask the data must equal the data value register.
- R6: Control bit 0 is the fetch flag, active low: 1 means a data access. Control bit 1 is the direction: 1 means write, 0 means read. Each of these bits, when unmasked, must match. Masking bit 1 matches both reads and writes.
- R7: Control bits 3:2 hold the access size. When these bits are unmasked the size must match, and when they are masked every size matches.
- R8: Control bit 4 holds the privilege flag (1 = non-user, 0 = user). When this bit is unmasked, it limits matches to one privilege level.
- R9: Control bit 5 compares against `ext_cond` and control bit 6 against `chain_in`. When either bit is unmasked with value 1, its input must be high for a hit.
- R10: Control bit 7 compares against `range_in`. `range_out` always equals `wp_hit`.
- R11: The selector codes are 0 for address value, 1 for address mask, 2 for data value, 3 for data mask, 4 for control value and 5 for control mask. Codes 6 and 7 change nothing. A write takes effect at the clock edge that samples it, so an access in that same cycle is still compared against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, is released synchronously |
| reg_wr_en | input | 1 | Register write enable |
| reg_sel | input | 3 | Register selector (R11 encoding) |
| reg_wdata | input | WR_W | Write data. Each register uses the low bits it needs |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Observed address |
| acc_data | input | DATA_W | Observed data |
| acc_fetch_n | input | 1 | 0 = opcode fetch, 1 = data access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size code |
| acc_priv | input | 1 | 1 = non-user mode, 0 = user mode |
| ext_cond | input | 1 | External condition |
| chain_in | input | 1 | Match from the chained unit |
| range_in | input | 1 | Range output of the neighbouring unit |
| wp_hit | output | 1 | Registered match |
| range_out | output | 1 | Copy of the match for a neighbour |

## Verification
The embedded assertions check several properties on every cycle. A hit never appears without a strobe on the edge before it. An exact-address mask never lets a different address through. A clear chain input blocks a hit whenever the chain bit is demanded. The register bank holds its contents when no write is enabled, and a mask written through the port is the value loaded. Other behaviour needs the bench's scenarios to show it. These are the aligned-block range match, the direction, size and privilege selections, the ignored selector codes, and the ordering of a write against an access in the same cycle.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  localparam int CTRL_W = 8;

  // control word bit positions (observed word is packed in this order)
  localparam int CB_FETCH_N = 0;
  localparam int CB_WRITE   = 1;
  localparam int CB_SIZE_LO = 2;
  localparam int CB_SIZE_HI = 3;
  localparam int CB_PRIV    = 4;
  localparam int CB_EXT     = 5;
  localparam int CB_CHAIN   = 6;
  localparam int CB_RANGE   = 7;

  typedef enum logic [2:0] {
    SEL_AVAL = 3'd0,
    SEL_AMSK = 3'd1,
    SEL_DVAL = 3'd2,
    SEL_DMSK = 3'd3,
    SEL_CVAL = 3'd4,
    SEL_CMSK = 3'd5
  } wpt_sel_e;

endpackage

// File: rtl/wpt_mask_cmp.sv
module wpt_mask_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] obs,
  output logic         hit
);
  logic [W-1:0] bit_ok;

  // one equality-or-ignore cell per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = (obs[i] ~^ value[i]) | mask[i];
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/wpt_ctrl_pack.sv
module wpt_ctrl_pack
  import wpt_pkg::*;
(
  input  logic              fetch_n,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic              priv,
  input  logic              ext,
  input  logic              chain,
  input  logic              rng,
  output logic [CTRL_W-1:0] word
);
  always_comb begin
    word                        = '0;
    word[CB_FETCH_N]            = fetch_n;
    word[CB_WRITE]              = write;
    word[CB_SIZE_HI:CB_SIZE_LO] = size;
    word[CB_PRIV]               = priv;
    word[CB_EXT]                = ext;
    word[CB_CHAIN]              = chain;
    word[CB_RANGE]              = rng;
  end
endmodule

// File: rtl/wpt_regbank.sv
module wpt_regbank
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WR_W-1:0]   wr_data,
  output logic [ADDR_W-1:0] aval,
  output logic [ADDR_W-1:0] amsk,
  output logic [DATA_W-1:0] dval,
  output logic [DATA_W-1:0] dmsk,
  output logic [CTRL_W-1:0] cval,
  output logic [CTRL_W-1:0] cmsk
);
  logic [ADDR_W-1:0] aval_d, amsk_d;
  logic [DATA_W-1:0] dval_d, dmsk_d;
  logic [CTRL_W-1:0] cval_d, cmsk_d;

  always_comb begin
    aval_d = aval;
    amsk_d = amsk;
    dval_d = dval;
    dmsk_d = dmsk;
    cval_d = cval;
    cmsk_d = cmsk;
    if (wr_en) begin
      case (wr_sel)
        SEL_AVAL: aval_d = wr_data[ADDR_W-1:0];
        SEL_AMSK: amsk_d = wr_data[ADDR_W-1:0];
        SEL_DVAL: dval_d = wr_data[DATA_W-1:0];
        SEL_DMSK: dmsk_d = wr_data[DATA_W-1:0];
        SEL_CVAL: cval_d = wr_data[CTRL_W-1:0];
        SEL_CMSK: cmsk_d = wr_data[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aval <= '0;
      amsk <= '1;
      dval <= '0;
      dmsk <= '1;
      cval <= '0;
      cmsk <= '1;
    end else begin
      aval <= aval_d;
      amsk <= amsk_d;
      dval <= dval_d;
      dmsk <= dmsk_d;
      cval <= cval_d;
      cmsk <= cmsk_d;
    end
  end

  // R11: registers hold when no write is enabled
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(aval) && $stable(amsk) && $stable(dval) &&
                $stable(dmsk) && $stable(cval) && $stable(cmsk)));

  // R11: an address-mask write loads the written word
  assert_amsk_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_AMSK) |=> amsk == $past(wr_data[ADDR_W-1:0]));

endmodule

// File: rtl/wpt_match_unit.sv
module wpt_match_unit
  import wpt_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  localparam int WR_W   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_sel,
  input  logic [WR_W-1:0]   reg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              acc_fetch_n,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic              acc_priv,
  input  logic              ext_cond,
  input  logic              chain_in,
  input  logic              range_in,
  output logic              wp_hit,
  output logic              range_out
);
  logic [ADDR_W-1:0] aval, amsk;
  logic [DATA_W-1:0] dval, dmsk;
  logic [CTRL_W-1:0] cval, cmsk, cobs;
  logic              a_hit, d_hit, c_hit;
  logic              hit_d, hit_q;

  wpt_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_W(WR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .aval(aval), .amsk(amsk), .dval(dval),
    .dmsk(dmsk), .cval(cval), .cmsk(cmsk)
  );

  wpt_ctrl_pack u_pack (
    .fetch_n(acc_fetch_n), .write(acc_write), .size(acc_size),
    .priv(acc_priv), .ext(ext_cond), .chain(chain_in), .rng(range_in),
    .word(cobs)
  );

  wpt_mask_cmp #(.W(ADDR_W)) u_acmp (.value(aval), .mask(amsk), .obs(acc_addr), .hit(a_hit));
  wpt_mask_cmp #(.W(DATA_W)) u_dcmp (.value(dval), .mask(dmsk), .obs(acc_data), .hit(d_hit));
  wpt_mask_cmp #(.W(CTRL_W)) u_ccmp (.value(cval), .mask(cmsk), .obs(cobs),     .hit(c_hit));

  always_comb begin
    hit_d = acc_valid & a_hit & d_hit & c_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign wp_hit    = hit_q;
  assign range_out = hit_q;

  // R2: a hit is always preceded by a strobe
  assert_hit_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> $past(acc_valid));

  // R3: exact address mask rejects any other address
  assert_exact_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && amsk == '0 && acc_addr != aval) |=> !wp_hit);

  // R5: with data fully masked, address and control alone decide
  assert_data_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (&dmsk) && a_hit && c_hit) |=> wp_hit);

  // R9: a demanded chain input that is low blocks the hit
  assert_chain_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !cmsk[CB_CHAIN] && cval[CB_CHAIN] && !chain_in) |=> !wp_hit);

endmodule

// File: tb/sim_wpt_match_unit.sv
module sim_wpt_match_unit;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_data = '0;
  logic acc_fetch_n = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
  logic [1:0] acc_size = '0;
  logic ext_cond = 1'b0, chain_in = 1'b0, range_in = 1'b0;
  logic wp_hit, range_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];

  // bench model of programmed registers
  logic [31:0] m_av, m_am, m_dv, m_dm;
  logic [7:0]  m_cv, m_cm;

  always #(CLK_P/2) clk = ~clk;

  wpt_match_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_data(acc_data), .acc_fetch_n(acc_fetch_n), .acc_write(acc_write),
    .acc_size(acc_size), .acc_priv(acc_priv), .ext_cond(ext_cond),
    .chain_in(chain_in), .range_in(range_in), .wp_hit(wp_hit),
    .range_out(range_out)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic [31:0] a, input logic [31:0] d,
                                     input logic [7:0] c);
    return (&((~(a ^ m_av)) | m_am)) & (&((~(d ^ m_dv)) | m_dm)) &
           (&((~(c ^ m_cv)) | m_cm));
  endfunction

  function automatic void model_wr(input logic [2:0] sel, input logic [31:0] v);
    case (sel)
      3'd0: m_av = v;
      3'd1: m_am = v;
      3'd2: m_dv = v;
      3'd3: m_dm = v;
      3'd4: m_cv = v[7:0];
      3'd5: m_cm = v[7:0];
      default: ;
    endcase
  endfunction

  // ctrl: bit0 fetch_n, bit1 write, 3:2 size, 4 priv, 5 ext, 6 chain, 7 range
  task automatic drive_bus(input logic [31:0] a, input logic [31:0] d, input logic [7:0] c);
    acc_addr = a; acc_data = d;
    acc_fetch_n = c[0]; acc_write = c[1]; acc_size = c[3:2];
    acc_priv = c[4]; ext_cond = c[5]; chain_in = c[6]; range_in = c[7];
  endtask

  task automatic access(input logic [31:0] a, input logic [31:0] d,
                        input logic [7:0] c, input string tag);
    item_t it;
    @(negedge clk);
    reg_wr_en = 1'b0;
    drive_bus(a, d, c);
    acc_valid = 1'b1;
    it.exp = model_hit(a, d, c);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    item_t it;
    @(negedge clk);
    reg_wr_en = 1'b0;
    acc_valid = 1'b0;
    drive_bus('1, '1, 8'hFF);
    it.exp = 1'b0;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] v);
    @(negedge clk);
    acc_valid = 1'b0;
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = v;
    model_wr(sel, v);
  endtask

  // write and access in the same cycle: access sees old contents
  task automatic wr_access(input logic [2:0] sel, input logic [31:0] v,
                           input logic [31:0] a, input logic [7:0] c, input string tag);
    item_t it;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = v;
    drive_bus(a, 32'h0, c);
    acc_valid = 1'b1;
    it.exp = model_hit(a, 32'h0, c);
    it.tag = tag;
    q.push_back(it);
    model_wr(sel, v);
  endtask

  task automatic model_reset();
    m_av = '0; m_am = '1; m_dv = '0; m_dm = '1; m_cv = '0; m_cm = '1;
  endtask

  // monitor: pops one expected item per strobed/idle driven cycle
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        #(CLK_P/4);
        check(wp_hit, it.exp, it.tag);
        if (it.tag == "R10") check(range_out, it.exp, "R10 range_out");
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    #(CLK_P * 3 + 2);
    check(wp_hit, 1'b0, "R1 reset hit");
    check(range_out, 1'b0, "R1 reset range");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: all masks set -> any access hits
    access(32'hDEAD_BEEF, 32'h1234_5678, 8'h5A, "R1");
    idle("R2");
    access(32'h0, 32'h0, 8'h00, "R1");
    idle("R2");

    // R3: exact address
    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'h0);
    access(32'h0000_1000, 32'h0, 8'h00, "R3");
    access(32'h0000_1004, 32'h0, 8'h00, "R3");
    access(32'h8000_1000, 32'h0, 8'h00, "R3");

    // R4: aligned block of 16
    wr(3'd1, 32'h0000_000F);
    access(32'h0000_100C, 32'h0, 8'h00, "R4");
    access(32'h0000_1000, 32'h0, 8'h00, "R4");
    access(32'h0000_1010, 32'h0, 8'h00, "R4");
    access(32'h0000_0FFF, 32'h0, 8'h00, "R4");

    // R5: data match
    wr(3'd2, 32'h0000_CAFE);
    access(32'h0000_1004, 32'h1111_2222, 8'h00, "R5");
    access(32'h0000_1004, 32'h0000_CAFE, 8'h00, "R5");
    wr(3'd3, 32'h0);
    access(32'h0000_1004, 32'h1111_2222, 8'h00, "R5");
    access(32'h0000_1004, 32'h0000_CAFE, 8'h00, "R5");
    wr(3'd3, 32'hFFFF_FFFF);

    // R6: data write only
    wr(3'd4, 32'h0000_0003);
    wr(3'd5, 32'h0000_00FC);
    access(32'h0000_1004, 32'h0, 8'h03, "R6");
    access(32'h0000_1004, 32'h0, 8'h01, "R6");
    access(32'h0000_1004, 32'h0, 8'h02, "R6");
    wr(3'd5, 32'h0000_00FE);
    access(32'h0000_1004, 32'h0, 8'h01, "R6");
    access(32'h0000_1004, 32'h0, 8'h00, "R6");

    // R7: size
    wr(3'd4, 32'h0000_0008);
    wr(3'd5, 32'h0000_00F3);
    access(32'h0000_1004, 32'h0, 8'h08, "R7");
    access(32'h0000_1004, 32'h0, 8'h04, "R7");
    access(32'h0000_1004, 32'h0, 8'h0C, "R7");
    wr(3'd5, 32'h0000_00FF);
    access(32'h0000_1004, 32'h0, 8'h04, "R7");

    // R8: privilege
    wr(3'd4, 32'h0000_0000);
    wr(3'd5, 32'h0000_00EF);
    access(32'h0000_1004, 32'h0, 8'h00, "R8");
    access(32'h0000_1004, 32'h0, 8'h10, "R8");
    wr(3'd4, 32'h0000_0010);
    access(32'h0000_1004, 32'h0, 8'h10, "R8");
    access(32'h0000_1004, 32'h0, 8'h00, "R8");

    // R9: external and chain
    wr(3'd4, 32'h0000_0060);
    wr(3'd5, 32'h0000_00DF);
    access(32'h0000_1004, 32'h0, 8'h00, "R9");
    access(32'h0000_1004, 32'h0, 8'h20, "R9");
    wr(3'd5, 32'h0000_00BF);
    access(32'h0000_1004, 32'h0, 8'h20, "R9");
    access(32'h0000_1004, 32'h0, 8'h40, "R9");

    // R10: range input bit, range_out mirror
    wr(3'd4, 32'h0000_0080);
    wr(3'd5, 32'h0000_007F);
    access(32'h0000_1004, 32'h0, 8'h80, "R10");
    access(32'h0000_1004, 32'h0, 8'h00, "R10");
    access(32'h0000_1004, 32'h0, 8'h80, "R10");

    // R11: unused selectors leave state untouched
    wr(3'd5, 32'h0000_00FF);
    wr(3'd1, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd7, 32'hFFFF_FFFF);
    access(32'h0000_1000, 32'h0, 8'h00, "R11");
    access(32'h0000_1004, 32'h0, 8'h00, "R11");
    // R11: same-cycle write uses old value, next access uses new
    wr(3'd0, 32'h0000_2000);
    wr_access(3'd0, 32'h0000_3000, 32'h0000_3000, 8'h00, "R11");
    access(32'h0000_3000, 32'h0, 8'h00, "R11");
    access(32'h0000_2000, 32'h0, 8'h00, "R11");
    idle("R2");

    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule